// File: doc/BRIEF.md
# Deviation-Point Source Route Handler

This block is the route-selection stage of one router in a two-dimensional mesh. It looks at a packet's head flit and picks an exit port. The header carries source-routed commands, but only for the few routers that are marked as deviation points. A deviation point is a router where at least one path leaves the default dimension-ordered route. All other routers ignore those commands. They route by X first, then Y, using the destination coordinates.

Each router instance is set up at build time with its own coordinates and with a flag that says whether it is a deviation point. At a deviation point, the stage takes the lowest routing tag and sends the packet out of the port that tag names. It then rewrites the head flit so that the next deviation point on the path sees its own tag at the bottom of the list. A deviation point whose ports are incomplete can be built with one-bit tags. Such a tag picks between two ports that are fixed by parameters.

The stage adds one register of latency and takes a head flit on every cycle. If a deviation point sees a header with no tags left, it falls back to the default route and sets an error flag. The flag stays set until reset.

Top module: `dpr_route_stage`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `out_valid` and `err_no_tag` are 0.
- R2: `out_valid` equals the `in_valid` of the previous clock cycle.
- R3: The head flit packs four fields, from most significant to least: destination X, destination Y, tag count, and tag field. Port codes are 0 east, 1 west, 2 north, 3 south, 4 local. The default route works as follows. If destination X is larger than the router's own X, the exit is east. If it is smaller, the exit is west. If the X values are equal, the same rule on Y gives north (larger) or south (smaller). If both are equal, the exit is local.
- R4: A router that is not a deviation point ignores the tags. It uses the default route, and the flit it emits is bit-for-bit the flit it received.
- R5: A deviation point with two-bit tags, a nonzero count and a non-local destination exits by the lowest two tag bits: 00 east, 01 west, 10 north, 11 south.
- R6: When a deviation point uses a tag, the emitted flit has the tag field shifted right by the tag width and the count reduced by one. The coordinates are unchanged.
- R7: A head flit whose destination equals the router's own coordinates exits local, leaves the stage unchanged and raises no error, at every kind of router.
- R8: A deviation point that receives a non-local flit with a tag count of zero uses the default route, emits the flit unchanged and sets `err_no_tag` in the next cycle.
- R9: `err_no_tag` stays set until reset, whatever flits arrive after it is set.
- R10: With one-bit tags, tag bit 0 selects the first configured port when it is 0 and the second when it is 1. The tag field then shifts right by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A head flit is present on `in_flit` |
| in_flit | input | XW+YW+CNT_W+2*MAX_TAGS (27) | Incoming head flit |
| out_valid | output | 1 | Registered head flit and port are valid |
| out_port | output | 3 | Chosen exit port code |
| out_flit | output | 27 | Head flit as forwarded, with the tag consumed when one was used |
| err_no_tag | output | 1 | Sticky flag: a deviation point ran out of tags |

## Verification
The bench targets a destination on the router itself while tags are still present. A design that let the tag win there would send the packet away from its endpoint and drop a tag. It also drives a zero tag count at a deviation point: a faulty stage would decode stale bits as a port, wrap the count to all ones, or forget to raise the flag. Tags placed so that the lowest and the next pair differ show up a shift by the wrong width, or a decode of the wrong end of the field. The same traffic is sent to a plain router and to a one-bit-tag router, which exposes tags leaking into the default route and a swapped narrow-port mapping.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [2:0] {
    PORT_E = 3'd0,
    PORT_W = 3'd1,
    PORT_N = 3'd2,
    PORT_S = 3'd3,
    PORT_L = 3'd4
  } port_e;

  // two-bit tag: 00 east, 01 west, 10 north, 11 south
  function automatic port_e wide_tag_port(input logic [1:0] tag);
    case (tag)
      2'b00:   return PORT_E;
      2'b01:   return PORT_W;
      2'b10:   return PORT_N;
      default: return PORT_S;
    endcase
  endfunction
endpackage

// File: rtl/dpr_xy_calc.sv
module dpr_xy_calc
  import dpr_pkg::*;
#(
  parameter int XW   = 4,
  parameter int YW   = 4,
  parameter int MY_X = 2,
  parameter int MY_Y = 2
) (
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  output port_e         xy_port,
  output logic          is_local
);
  localparam logic [XW-1:0] SELF_X = XW'(MY_X);
  localparam logic [YW-1:0] SELF_Y = YW'(MY_Y);

  function automatic port_e xy_route(input logic [XW-1:0] dx, input logic [YW-1:0] dy);
    if (dx > SELF_X)      return PORT_E;
    else if (dx < SELF_X) return PORT_W;
    else if (dy > SELF_Y) return PORT_N;
    else if (dy < SELF_Y) return PORT_S;
    else                  return PORT_L;
  endfunction

  assign xy_port  = xy_route(dst_x, dst_y);
  assign is_local = (dst_x == SELF_X) && (dst_y == SELF_Y);
endmodule

// File: rtl/dpr_tag_pop.sv
module dpr_tag_pop
  import dpr_pkg::*;
#(
  parameter int MAX_TAGS = 8,
  parameter int CNT_W    = 3,
  parameter bit NARROW   = 1'b0,
  parameter int P0       = 2,
  parameter int P1       = 0
) (
  input  logic [2*MAX_TAGS-1:0] tags,
  input  logic [CNT_W-1:0]      cnt,
  output port_e                 tag_port,
  output logic                  has_tag,
  output logic [2*MAX_TAGS-1:0] new_tags,
  output logic [CNT_W-1:0]      new_cnt
);
  assign has_tag = |cnt;
  assign new_cnt = cnt - CNT_W'(1);

  generate
    if (NARROW) begin : g_narrow
      assign tag_port = tags[0] ? port_e'(3'(P1)) : port_e'(3'(P0));
      assign new_tags = tags >> 1;
    end else begin : g_wide
      assign tag_port = wide_tag_port(tags[1:0]);
      assign new_tags = tags >> 2;
    end
  endgenerate
endmodule

// File: rtl/dpr_route_stage.sv
module dpr_route_stage
  import dpr_pkg::*;
#(
  parameter int XW       = 4,
  parameter int YW       = 4,
  parameter int MAX_TAGS = 8,
  parameter int MY_X     = 2,
  parameter int MY_Y     = 2,
  parameter bit IS_DP    = 1'b1,
  parameter bit NARROW   = 1'b0,
  parameter int P0       = 2,
  parameter int P1       = 0,
  localparam int CNT_W   = $clog2(MAX_TAGS),
  localparam int TAGS_W  = 2 * MAX_TAGS,
  localparam int FLIT_W  = XW + YW + CNT_W + TAGS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              out_valid,
  output logic [2:0]        out_port,
  output logic [FLIT_W-1:0] out_flit,
  output logic              err_no_tag
);
  localparam int CNT_LO = TAGS_W;
  localparam int DY_LO  = TAGS_W + CNT_W;
  localparam int DX_LO  = DY_LO + YW;

  logic [XW-1:0]     in_dx;
  logic [YW-1:0]     in_dy;
  logic [CNT_W-1:0]  in_cnt;
  logic [TAGS_W-1:0] in_tags;
  assign in_tags = in_flit[TAGS_W-1:0];
  assign in_cnt  = in_flit[CNT_LO +: CNT_W];
  assign in_dy   = in_flit[DY_LO +: YW];
  assign in_dx   = in_flit[DX_LO +: XW];

  port_e             xy_port, tag_port, nxt_port, port_q;
  logic              is_local, has_tag;
  logic [TAGS_W-1:0] new_tags;
  logic [CNT_W-1:0]  new_cnt;

  dpr_xy_calc #(.XW(XW), .YW(YW), .MY_X(MY_X), .MY_Y(MY_Y)) u_xy (
    .dst_x(in_dx), .dst_y(in_dy), .xy_port(xy_port), .is_local(is_local)
  );

  dpr_tag_pop #(.MAX_TAGS(MAX_TAGS), .CNT_W(CNT_W), .NARROW(NARROW),
                .P0(P0), .P1(P1)) u_pop (
    .tags(in_tags), .cnt(in_cnt), .tag_port(tag_port), .has_tag(has_tag),
    .new_tags(new_tags), .new_cnt(new_cnt)
  );

  // named events for the checks below
  logic tag_taken, underflow;
  assign tag_taken = in_valid && IS_DP && !is_local && has_tag;
  assign underflow = in_valid && IS_DP && !is_local && !has_tag;

  logic [FLIT_W-1:0] nxt_flit;
  assign nxt_port = tag_taken ? tag_port : xy_port;
  assign nxt_flit = tag_taken ? {in_dx, in_dy, new_cnt, new_tags} : in_flit;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      port_q     <= PORT_L;
      out_flit   <= '0;
      err_no_tag <= 1'b0;
      past_ok    <= 1'b0;
    end else begin
      past_ok   <= 1'b1;
      out_valid <= in_valid;
      if (in_valid) begin
        port_q   <= nxt_port;
        out_flit <= nxt_flit;
      end
      if (underflow) err_no_tag <= 1'b1;
    end
  end
  assign out_port = port_q;

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> out_valid == $past(in_valid));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_no_tag |=> err_no_tag);

  p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> err_no_tag);

  p_local_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flit[DX_LO +: XW] == XW'(MY_X) && out_flit[DY_LO +: YW] == YW'(MY_Y))
      |-> out_port == 3'(PORT_L));

  p_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tag_taken |=> out_flit[CNT_LO +: CNT_W] == $past(in_cnt) - CNT_W'(1));

  generate
    if (!IS_DP) begin : g_plain_chk
      p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_flit == $past(in_flit));
    end
  endgenerate
endmodule

// File: tb/dpr_route_stage_tb.sv
module dpr_route_stage_tb;
  localparam int CLK_P = 10;
  localparam int FW    = 27;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [FW-1:0] in_flit = '0;

  logic          v_a, v_b, v_c, e_a, e_b, e_c;
  logic [2:0]    p_a, p_b, p_c;
  logic [FW-1:0] f_a, f_b, f_c;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit xe_a, xe_c;

  always #(CLK_P/2) clk = ~clk;

  // deviation point, two-bit tags
  dpr_route_stage #(.IS_DP(1'b1), .NARROW(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
    .out_valid(v_a), .out_port(p_a), .out_flit(f_a), .err_no_tag(e_a));
  // ordinary router
  dpr_route_stage #(.IS_DP(1'b0)) u_plain (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
    .out_valid(v_b), .out_port(p_b), .out_flit(f_b), .err_no_tag(e_b));
  // deviation point, one-bit tags: 0 -> north, 1 -> east
  dpr_route_stage #(.IS_DP(1'b1), .NARROW(1'b1), .P0(2), .P1(0)) u_narrow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
    .out_valid(v_c), .out_port(p_c), .out_flit(f_c), .err_no_tag(e_c));

  function automatic int mk(int dx, int dy, int cnt, int tags);
    return ((dx % 16) * (1 << 23)) + ((dy % 16) * (1 << 19)) + ((cnt % 8) * (1 << 16)) + (tags % 65536);
  endfunction

  // behavioural reference: router at (2,2)
  function automatic void model(input int dx, input int dy, input int cnt, input int tags,
                                input bit dp, input bit nar,
                                output int port, output int oflit, output bit uf);
    uf = 0;
    oflit = mk(dx, dy, cnt, tags);
    if (dx == 2 && dy == 2) port = 4;
    else if (dp && cnt > 0) begin
      if (nar) begin port = (tags % 2) ? 0 : 2; oflit = mk(dx, dy, cnt - 1, tags / 2); end
      else     begin port = tags % 4;           oflit = mk(dx, dy, cnt - 1, tags / 4); end
    end else begin
      if (dx > 2)      port = 0;
      else if (dx < 2) port = 1;
      else if (dy > 2) port = 2;
      else             port = 3;
      uf = dp;
    end
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int dx, int dy, int cnt, int tags, bit v, string lp, string lf);
    int pa, pb, pc, fa, fb, fc;
    bit ua, ub, uc;
    model(dx, dy, cnt, tags, 1'b1, 1'b0, pa, fa, ua);
    model(dx, dy, cnt, tags, 1'b0, 1'b0, pb, fb, ub);
    model(dx, dy, cnt, tags, 1'b1, 1'b1, pc, fc, uc);
    in_flit  = FW'(mk(dx, dy, cnt, tags));
    in_valid = v;
    if (v && ua) xe_a = 1;
    if (v && uc) xe_c = 1;
    @(negedge clk);
    chk("R2 valid dp", int'(v_a), int'(v));
    chk("R2 valid plain", int'(v_b), int'(v));
    chk("R2 valid narrow", int'(v_c), int'(v));
    if (v) begin
      chk({lp, " port dp"}, int'(p_a), pa);
      chk({lf, " flit dp"}, int'(f_a), fa);
      chk("R3 port plain", int'(p_b), pb);
      chk("R4 flit plain", int'(f_b), fb);
      chk("R10 port narrow", int'(p_c), pc);
      chk("R10 flit narrow", int'(f_c), fc);
    end
    chk("R8 err dp", int'(e_a), int'(xe_a));
    chk("R4 err plain", int'(e_b), 0);
    chk("R8 err narrow", int'(e_c), int'(xe_c));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 valid in reset", int'(v_a | v_b | v_c), 0);
    chk("R1 err in reset", int'(e_a | e_b | e_c), 0);
    rst_n = 1'b1; xe_a = 0; xe_c = 0;
    @(negedge clk);
    chk("R1 valid after reset", int'(v_a | v_b | v_c), 0);
    chk("R1 err after reset", int'(e_a | e_b | e_c), 0);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    @(negedge clk);
    do_reset();
    step(5, 2, 2, 'b1110,   1, "R5", "R6");   // lowest tag north, next south
    step(0, 2, 1, 'b00,     1, "R5", "R6");
    step(2, 7, 3, 'b010111, 1, "R5", "R6");   // lowest tag south
    step(2, 0, 7, 'hAAAA,   1, "R5", "R6");   // full count
    step(2, 2, 2, 'b01,     1, "R7", "R7");   // local with tags left
    step(1, 1, 1, 'b11,     0, "R2", "R2");   // idle cycle
    step(6, 1, 0, 'b11,     1, "R8", "R8");   // no tags at deviation point
    step(2, 5, 0, 0,        1, "R8", "R8");
    step(3, 3, 2, 'b0110,   1, "R9", "R9");   // flag must persist
    step(2, 2, 0, 0,        1, "R9", "R7");
    chk("R9 sticky dp", int'(e_a), 1);
    do_reset();                               // clears the flag
    seed = 7;
    for (int i = 0; i < 60; i++) begin
      int dx, dy, cnt, tags;
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      dx = (seed >> 4) % 6; dy = (seed >> 8) % 6;
      cnt = (seed >> 12) % 8; tags = (seed >> 3) % 65536;
      step(dx, dy, cnt, tags, ((seed >> 20) % 4) != 0, "R5", "R6");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule